// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer with Standby Duty Cycling

The sequencer drives a multiplexed converter through the input channels that software has enabled. It visits them from the lowest index to the highest and passes over the disabled ones. On each visit it selects the channel and hands the filter that channel's own configuration. It then holds off for a settling time taken from the channel's own register, restarts the filter, and waits for a result that the filter marks as both valid and settled. That result is passed on with the channel number attached, and the sequencer moves to the next channel. Each channel yields exactly one result per pass.

Four run modes decide what happens between passes. In continuous mode a new pass starts at once. In sync mode the block waits in standby for a sync pulse, makes one pass, and returns to standby. The two duty-cycle modes add a standby interval after every pass. The length of that interval is derived from the measured length of the pass, so the block is active for one quarter or one sixteenth of each period. The analog multiplexer and the decimation filter live outside the block.

Top module: `chan_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, `standby` is 1 and `filt_restart`, `res_valid` and `mux_sel` are 0.
- R2: Within a pass, `mux_sel` visits the enabled channels in ascending index order and skips the disabled ones. It changes only on the clock edge that also raises `res_valid`.
- R3: When the sequencer switches to a channel, it holds that channel for max(setting, 4) cycles and then pulses `filt_restart` high for exactly one cycle. The setting is the 16-bit field at bits [16c+15:16c] of `settle_cfg` for channel c.
- R4: While a channel is selected, `filt_cfg_sel` equals that channel's 2-bit field at bits [2c+1:2c] of `filt_cfg`.
- R5: A filter output is accepted only on a cycle after the restart pulse that has both `filt_valid` and `filt_settled` high. The block ignores valid without settled, anything seen during the settling wait, and anything seen in the restart cycle.
- R6: An accepted output appears one cycle later as a single-cycle `res_valid`, with `res_chan` set to the 4-bit channel index and `res_data` set to the accepted data.
- R7: Each enabled channel produces exactly one result per pass. Consecutive results follow the ascending order and wrap from the highest enabled channel to the lowest.
- R8: With `run_mode` = 2'b00 (continuous), `standby` stays 0 across pass boundaries for as long as at least one channel is enabled.
- R9: With `run_mode` = 2'b01 (sync), the block leaves standby only in response to `sync_in`. It then makes one pass and returns to `standby` = 1.
- R10: With `run_mode` = 2'b10, each pass is followed by 3×A standby cycles, where A is the number of non-standby cycles in that pass. With `run_mode` = 2'b11, the pass is followed by 15×A standby cycles. A new pass then starts.
- R11: With no channel enabled, `standby` stays 1 and `filt_restart` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_mode | input | 2 | 00 continuous, 01 sync single pass, 10 quarter duty, 11 sixteenth duty |
| sync_in | input | 1 | Starts one pass in sync mode |
| ch_en | input | 16 | Channel enable mask |
| settle_cfg | input | 256 | Per-channel settle cycles, 16 bits each |
| filt_cfg | input | 32 | Per-channel filter configuration, 2 bits each |
| mux_sel | output | 4 | Selected input channel |
| filt_cfg_sel | output | 2 | Filter configuration of the selected channel |
| filt_restart | output | 1 | One-cycle filter restart after settling |
| filt_valid | input | 1 | Filter output strobe |
| filt_settled | input | 1 | Filter output has passed its latency |
| filt_data | input | 24 | Filter output word |
| standby | output | 1 | Converter may power down |
| res_valid | output | 1 | Result strobe |
| res_chan | output | 4 | Channel number of the result |
| res_data | output | 24 | Result word |

## Verification
On every cycle, the assertions check that the restart is a single pulse and never follows a standby cycle. They also check that a result always comes from a valid, settled filter output outside the restart cycle, that the channel select moves only together with a result, that continuous mode never drops into standby, and that sync mode wakes only on a sync pulse. The standby-to-active ratio of the duty modes depends on a measured pass length, and the settle count depends on per-channel registers. Both of these, along with result ordering and the idle behaviour with an empty mask, are shown only by the bench's scenarios: the per-cycle reference model and the run-length monitors that follow it.

// File: rtl/chan_seq.sv
module chan_seq #(
  parameter int NCH        = 16,
  parameter int SETTLE_W   = 16,
  parameter int FCFG_W     = 2,
  parameter int DATA_W     = 24,
  parameter int MIN_SETTLE = 4,
  parameter int ACT_W      = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 run_mode,
  input  logic                       sync_in,
  input  logic [NCH-1:0]             ch_en,
  input  logic [NCH*SETTLE_W-1:0]    settle_cfg,
  input  logic [NCH*FCFG_W-1:0]      filt_cfg,
  output logic [$clog2(NCH)-1:0]     mux_sel,
  output logic [FCFG_W-1:0]          filt_cfg_sel,
  output logic                       filt_restart,
  input  logic                       filt_valid,
  input  logic                       filt_settled,
  input  logic [DATA_W-1:0]          filt_data,
  output logic                       standby,
  output logic                       res_valid,
  output logic [$clog2(NCH)-1:0]     res_chan,
  output logic [DATA_W-1:0]          res_data
);
  localparam int CH_W  = $clog2(NCH);
  localparam int SLP_W = ACT_W + 4;
  localparam int CNT_W = (SLP_W > SETTLE_W) ? SLP_W : SETTLE_W;
  localparam logic [SETTLE_W-1:0] MIN_S = SETTLE_W'(MIN_SETTLE);

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_WAIT, ST_SLEEP} state_t;

  state_t           state;
  logic [CH_W-1:0]  ch, first_ch, next_ch;
  logic [CNT_W-1:0] cnt;
  logic [ACT_W-1:0] act;
  logic [SLP_W-1:0] act_n, slp_len;
  logic             any_en, has_next, accept, start_ok;

  function automatic logic [CNT_W-1:0] settle_load(input logic [CH_W-1:0] c);
    logic [SETTLE_W-1:0] v;
    v = settle_cfg[int'(c)*SETTLE_W +: SETTLE_W];
    if (v < MIN_S) v = MIN_S;
    return CNT_W'(v - 1'b1);
  endfunction

  always_comb begin
    first_ch = '0;
    next_ch  = '0;
    has_next = 1'b0;
    for (int i = NCH-1; i >= 0; i--) begin
      if (ch_en[i]) begin
        first_ch = CH_W'(i);
        if (i > int'(ch)) begin
          next_ch  = CH_W'(i);
          has_next = 1'b1;
        end
      end
    end
  end

  assign any_en   = |ch_en;
  assign start_ok = any_en && (run_mode != 2'b01 || sync_in);
  assign accept   = (state == ST_WAIT) && !filt_restart && filt_valid && filt_settled;
  assign act_n    = SLP_W'(act) + 1'b1;
  assign slp_len  = run_mode[0] ? ((act_n << 4) - act_n - 1'b1)
                                : ((act_n << 1) + act_n - 1'b1);

  assign mux_sel      = ch;
  assign filt_cfg_sel = filt_cfg[int'(ch)*FCFG_W +: FCFG_W];
  assign standby      = (state == ST_IDLE) || (state == ST_SLEEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      ch           <= '0;
      cnt          <= '0;
      act          <= '0;
      filt_restart <= 1'b0;
      res_valid    <= 1'b0;
      res_chan     <= '0;
      res_data     <= '0;
    end else begin
      filt_restart <= (state == ST_SETTLE) && (cnt == '0);
      res_valid    <= accept;
      if (accept) begin
        res_chan <= ch;
        res_data <= filt_data;
      end
      case (state)
        ST_IDLE, ST_SLEEP: begin
          if (state == ST_IDLE || cnt == '0) begin
            if (start_ok) begin
              state <= ST_SETTLE;
              ch    <= first_ch;
              cnt   <= settle_load(first_ch);
              act   <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_SETTLE: begin
          act <= act + 1'b1;
          if (cnt == '0) state <= ST_WAIT;
          else           cnt   <= cnt - 1'b1;
        end
        default: begin
          act <= act + 1'b1;
          if (accept) begin
            if (has_next) begin
              state <= ST_SETTLE;
              ch    <= next_ch;
              cnt   <= settle_load(next_ch);
            end else begin
              case (run_mode)
                2'b00: begin
                  if (any_en) begin
                    state <= ST_SETTLE;
                    ch    <= first_ch;
                    cnt   <= settle_load(first_ch);
                    act   <= '0;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                2'b01: state <= ST_IDLE;
                default: begin
                  state <= ST_SLEEP;
                  cnt   <= CNT_W'(slp_len);
                end
              endcase
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/chan_seq_chk.sv
module chan_seq_chk #(
  parameter int NCH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             run_mode,
  input logic                   sync_in,
  input logic [NCH-1:0]         ch_en,
  input logic [$clog2(NCH)-1:0] mux_sel,
  input logic                   filt_restart,
  input logic                   filt_valid,
  input logic                   filt_settled,
  input logic                   standby,
  input logic                   res_valid
);
  // R3
  restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filt_restart |=> !filt_restart);

  // R11
  idle_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !filt_restart);

  // R5
  result_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(filt_valid && filt_settled && !filt_restart));

  // R2
  switch_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby && $past(!standby) && mux_sel != $past(mux_sel)) |-> res_valid);

  // R8
  continuous_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode == 2'b00 && !standby && |ch_en) |=> !standby);

  // R9
  sync_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && run_mode == 2'b01) |=> (standby || $past(sync_in)));
endmodule

bind chan_seq chan_seq_chk #(.NCH(NCH)) i_chk (
  .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .sync_in(sync_in), .ch_en(ch_en),
  .mux_sel(mux_sel), .filt_restart(filt_restart), .filt_valid(filt_valid),
  .filt_settled(filt_settled), .standby(standby), .res_valid(res_valid)
);

// File: tb/test_chan_seq.sv
`timescale 1ns/1ps
module test_chan_seq;
  localparam int NCH = 16, SW = 16, FW = 2, DW = 24;

  logic clk = 1'b0, rst_n = 1'b0, sync_in = 1'b0;
  logic [1:0] run_mode = 2'b00;
  logic [NCH-1:0] ch_en = '0;
  logic [NCH*SW-1:0] settle_cfg = '0;
  logic [NCH*FW-1:0] filt_cfg = '0;
  logic filt_valid = 1'b0, filt_settled = 1'b0;
  logic [DW-1:0] filt_data = '0;
  logic [3:0] mux_sel, res_chan;
  logic [FW-1:0] filt_cfg_sel;
  logic filt_restart, standby, res_valid;
  logic [DW-1:0] res_data;

  chan_seq i_chan_seq (
    .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .sync_in(sync_in), .ch_en(ch_en),
    .settle_cfg(settle_cfg), .filt_cfg(filt_cfg), .mux_sel(mux_sel),
    .filt_cfg_sel(filt_cfg_sel), .filt_restart(filt_restart), .filt_valid(filt_valid),
    .filt_settled(filt_settled), .filt_data(filt_data), .standby(standby),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data)
  );

  always #2.5 clk = ~clk;

  int vec = 0, err = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input string tag, input int got, input int exp);
    vec++;
    if (got != exp) begin
      err++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, err);
      $finish;
    end
  endtask

  function automatic int stl(input int c);
    int v = int'(settle_cfg[c*SW +: SW]);
    return (v < 4) ? 4 : v;
  endfunction
  function automatic int first_en();
    for (int i = 0; i < NCH; i++) if (ch_en[i]) return i;
    return -1;
  endfunction
  function automatic int next_en(input int c);
    for (int i = c + 1; i < NCH; i++) if (ch_en[i]) return i;
    return -1;
  endfunction

  // filter stand-in: valid every 3 cycles after restart, settled from the 3rd or 4th output
  bit glitch = 0;
  int fcnt = 0, nval = 0, seqv = 1;
  always @(negedge clk) begin
    if (glitch) begin
      filt_valid = 1; filt_settled = 1; filt_data = DW'(seqv); seqv++;
    end else begin
      if (filt_restart) begin fcnt = 0; nval = 0; end else fcnt++;
      filt_valid = (fcnt > 0) && (fcnt % 3 == 0);
      if (filt_valid) begin nval++; seqv++; end
      filt_settled = filt_valid && (nval >= (filt_cfg_sel[0] ? 4 : 3));
      filt_data = DW'(seqv);
    end
  end

  // behavioural reference: 0 idle, 1 settling, 2 waiting for filter, 3 sleeping
  int ms = 0, mch = 0, mcnt = 0, mact = 0, mrs = 0, mrv = 0, mrc = 0, mrd = 0;
  always @(posedge clk) begin
    int acc, nrs, f, n;
    if (!rst_n) begin
      ms = 0; mch = 0; mcnt = 0; mact = 0; mrs = 0; mrv = 0; mrc = 0; mrd = 0;
    end else begin
      acc = (ms == 2 && mrs == 0 && filt_valid && filt_settled);
      nrs = (ms == 1 && mcnt == 0);
      mrv = acc;
      if (acc) begin mrc = mch; mrd = int'(filt_data); end
      if (ms == 0 || (ms == 3 && mcnt == 0)) begin
        f = first_en();
        if (f >= 0 && (run_mode != 2'b01 || sync_in)) begin
          ms = 1; mch = f; mcnt = stl(f) - 1; mact = 0;
        end else ms = 0;
      end else if (ms == 3) mcnt--;
      else if (ms == 1) begin
        mact++;
        if (mcnt == 0) ms = 2; else mcnt--;
      end else begin
        mact++;
        if (acc) begin
          n = next_en(mch);
          if (n >= 0) begin ms = 1; mch = n; mcnt = stl(n) - 1; end
          else if (run_mode == 2'b00) begin
            f = first_en();
            if (f >= 0) begin ms = 1; mch = f; mcnt = stl(f) - 1; mact = 0; end
            else ms = 0;
          end else if (run_mode == 2'b01) ms = 0;
          else begin ms = 3; mcnt = mact * (run_mode == 2'b10 ? 3 : 15) - 1; end
        end
      end
      mrs = nrs;
    end
  end

  // monitors
  bit ordchk = 0, dchk = 0, fresh = 0, prev_sb = 1;
  int last_rc = -1, a_run = 0, s_run = 0, last_a = 0, sw = 0, rst_cnt = 0, res_cnt = 0;

  always @(posedge clk) begin
    string sbtag;
    #1;
    cyc++;
    if (!rst_n) begin
      chk("R1 standby", standby, 1);
      chk("R1 restart", filt_restart, 0);
      chk("R1 res_valid", res_valid, 0);
      chk("R1 mux_sel", mux_sel, 0);
    end else begin
      sbtag = (ch_en == 0) ? "R11" : (run_mode == 2'b00) ? "R8" : (run_mode == 2'b01) ? "R9" : "R10";
      chk(sbtag, standby, (ms == 0 || ms == 3));
      chk("R3 restart", filt_restart, mrs);
      chk("R6 res_valid", res_valid, mrv);
      if (mrv) begin
        chk("R6 res_chan", res_chan, mrc);
        chk("R6 res_data", int'(res_data), mrd);
      end
      if (ms == 1 || ms == 2) begin
        chk("R2 mux_sel", mux_sel, mch);
        chk("R4 filt_cfg_sel", filt_cfg_sel, int'(filt_cfg[mch*FW +: FW]));
      end
      if (filt_restart) chk("R3 settle span", cyc - sw, stl(mux_sel));
      if ((prev_sb && !standby) || res_valid) sw = cyc;
      if (filt_restart) rst_cnt++;
      if (res_valid) res_cnt++;
      if (ordchk && res_valid) begin
        if (last_rc >= 0)
          chk("R7 order", res_chan, next_en(last_rc) >= 0 ? next_en(last_rc) : first_en());
        last_rc = res_chan;
      end
      if (!standby) begin
        if (prev_sb) begin
          if (dchk && last_a > 0) chk("R10 standby span", s_run, last_a * (run_mode == 2'b10 ? 3 : 15));
          a_run = 0; fresh = dchk;
        end
        a_run++;
      end else begin
        if (!prev_sb) begin last_a = fresh ? a_run : 0; s_run = 0; end
        s_run++;
      end
      prev_sb = standby;
    end
  end

  initial begin
    #750000;
    err++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      settle_cfg[i*SW +: SW] = (i % 3 == 0) ? SW'(i % 2) : SW'(4 + i);
      filt_cfg[i*FW +: FW] = FW'(i % 4);
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    // continuous scan with gaps in the mask
    ch_en = 16'b1010_0000_0100_1101; run_mode = 2'b00; ordchk = 1;
    repeat (600) @(negedge clk);
    // unsettled / stale filter activity must be ignored
    glitch = 1;
    repeat (200) @(negedge clk);
    glitch = 0; ordchk = 0;
    repeat (100) @(negedge clk);
    // empty mask: stays idle
    ch_en = '0;
    repeat (100) @(negedge clk);
    rst_cnt = 0;
    repeat (200) @(negedge clk);
    chk("R11 restarts with empty mask", rst_cnt, 0);
    chk("R11 standby held", standby, 1);
    // sync single pass
    run_mode = 2'b01; ch_en = 16'h8011;
    repeat (50) @(negedge clk);
    chk("R9 waits for sync", standby, 1);
    res_cnt = 0;
    sync_in = 1; @(negedge clk); sync_in = 0;
    repeat (300) @(negedge clk);
    chk("R9 one result per channel", res_cnt, 3);
    chk("R9 back in standby", standby, 1);
    sync_in = 1; @(negedge clk); sync_in = 0;
    repeat (300) @(negedge clk);
    // quarter duty
    run_mode = 2'b10; ch_en = 16'h0006; dchk = 1; last_a = 0; fresh = 0;
    repeat (900) @(negedge clk);
    dchk = 0;
    // sixteenth duty
    run_mode = 2'b11; ch_en = 16'h0041;
    repeat (5) @(negedge clk);
    dchk = 1; last_a = 0; fresh = 0;
    repeat (2500) @(negedge clk);
    dchk = 0;
    finish_run();
  end
endmodule